// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects the event flags of an Ethernet MAC into one 32-bit event word, qualifies them with a 32-bit enable mask, and drives thirteen separate interrupt lines. Each event has its own line, so a CPU interrupt controller sees each cause on its own input rather than one combined request. The transmit engine, the receive engine and the PHY management logic raise events through one-cycle pulses on a source vector. Software sees the event word and the mask through a small register bus. It acknowledges events by writing ones to the event word and programs the mask with a plain write.

A write to the transmit control location with bit 0 set asks for a graceful stop. Transmission completes at once, so such a write raises the graceful-stop-done event in the same cycle. Each interrupt line is a flop. It follows the masked state one clock after the event or mask storage changes.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the event word reads 0, the mask reads 0 and all thirteen interrupt lines are low.
- R2: A pulse on source input `src_pulse[i]` sets one event bit. The bit positions for i = 0..12 are, in that order: 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. These are transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, management, late collision, heartbeat, graceful stop done, bus error, babbling transmit and babbling receive.
- R3: A bus write to offset 0x004 clears each event bit whose written bit is 1. Event bits written as 0 keep their value.
- R4: A bus write to offset 0x008 replaces all 32 mask bits, and a read of 0x008 returns the written value.
- R5: Interrupt line `irq_o[i]` is high exactly when the event bit listed for index i in R2 and the same bit of the mask are both 1.
- R6: A bus write to offset 0x0C4 with bit 0 set sets the graceful-stop-done event (bit 28). A write there with bit 0 clear changes no event bit.
- R7: If a source pulse and a write-one clear hit the same event bit in the same cycle, the bit ends up set.
- R8: The interrupt lines are registered. After a clock edge that changes the event or mask storage, the lines still show the old state. They show the new state after the following edge.
- R9: Event bits outside the thirteen listed positions always read 0, even after a write of all ones to 0x004. A read of any offset other than 0x004 and 0x008 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_pulse | input | 13 | Event pulses from the engines, in line order |
| irq_o | output | 13 | Per-event interrupt lines, registered |

## Verification
The bench builds the block with its default parameters: a 10-bit offset space with the event word at 0x004, the mask at 0x008 and transmit control at 0x0C4. These values place all three decoded locations in one small address range. Unused offsets such as 0x00C can then be probed to check that they read zero. The fixed thirteen-entry mapping stays small enough that the bench walks every line one by one. It also drives all lines at once against a patterned mask, and lines up a source pulse with a clear of the same bit in a single cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int LINE_CNT  = 13;
  localparam int WORD_W    = 32;
  localparam int GRACE_IDX = 9;

  // Event bit position for each interrupt line index (line order fixed).
  function automatic int unsigned line_bit(int unsigned idx);
    case (idx)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction

  // Place a line-ordered vector onto its event-word positions.
  function automatic logic [WORD_W-1:0] spread(logic [LINE_CNT-1:0] src);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < LINE_CNT; i++) w[line_bit(i)] = src[i];
    return w;
  endfunction

  // Pick line-ordered bits back out of an event word.
  function automatic logic [LINE_CNT-1:0] gather(logic [WORD_W-1:0] w);
    logic [LINE_CNT-1:0] v;
    for (int i = 0; i < LINE_CNT; i++) v[i] = w[line_bit(i)];
    return v;
  endfunction

  // Mask of implemented event bits.
  function automatic logic [WORD_W-1:0] impl_bits();
    return spread({LINE_CNT{1'b1}});
  endfunction
endpackage

// File: rtl/evt_bus_decode.sv
module evt_bus_decode #(
  parameter int ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] EVT_OFS   = 10'h004,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 10'h008,
  parameter logic [ADDR_W-1:0] TXCTL_OFS = 10'h0C4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit_evt,
  output logic              hit_mask,
  output logic              clr_we,
  output logic              mask_we,
  output logic              txctl_we
);
  assign hit_evt  = (addr == EVT_OFS);
  assign hit_mask = (addr == MASK_OFS);
  assign clr_we   = wr && hit_evt;
  assign mask_we  = wr && hit_mask;
  assign txctl_we = wr && (addr == TXCTL_OFS);

  always_comb begin
    assert ($countones({clr_we, mask_we, txctl_we}) <= 1)
      else $error("a_r9_one_target: write strobes more than one location");
  end
endmodule

// File: rtl/evt_store.sv
module evt_store
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] clr_val,
  input  logic              mask_we,
  input  logic [WORD_W-1:0] mask_val,
  output logic [WORD_W-1:0] evt_q,
  output logic [WORD_W-1:0] mask_q
);
  localparam logic [WORD_W-1:0] IMPL = impl_bits();

  logic [WORD_W-1:0] clr_eff;
  logic [WORD_W-1:0] evt_d;

  assign clr_eff = clr_we ? clr_val : '0;
  // Set is applied after clear so a same-cycle set wins.
  assign evt_d   = ((evt_q & ~clr_eff) | set_vec) & IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (mask_we) mask_q <= mask_val;
    end
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((evt_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));
  a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((evt_q & $past(clr_val & ~set_vec)) == '0));
  a_r2_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(set_vec)) == '0));
  a_r4_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_val)));
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~IMPL) == '0);
endmodule

// File: rtl/evt_line_out.sv
module evt_line_out
  import evt_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   active_word,
  output logic [LINE_CNT-1:0] irq_q
);
  logic [LINE_CNT-1:0] active_lines;
  logic [LINE_CNT-1:0] changed;

  assign active_lines = gather(active_word);
  assign changed      = active_lines ^ irq_q;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)          irq_q[g] <= 1'b0;
      else if (changed[g]) irq_q[g] <= active_lines[g];
    end
  end

  a_r8_follow_next: assert property (@(posedge clk) disable iff (!rst_n)
    (|changed) |=> (irq_q == $past(active_lines)));
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (changed == '0) |=> $stable(irq_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] EVT_OFS   = 10'h004,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 10'h008,
  parameter logic [ADDR_W-1:0] TXCTL_OFS = 10'h0C4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [LINE_CNT-1:0] src_pulse,
  output logic [LINE_CNT-1:0] irq_o
);
  logic hit_evt, hit_mask, clr_we, mask_we, txctl_we;
  logic grace_req;
  logic [LINE_CNT-1:0] set_lines;
  logic [WORD_W-1:0]   set_vec, evt_q, mask_q, active_word;

  evt_bus_decode #(
    .ADDR_W(ADDR_W), .EVT_OFS(EVT_OFS), .MASK_OFS(MASK_OFS), .TXCTL_OFS(TXCTL_OFS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit_evt(hit_evt), .hit_mask(hit_mask),
    .clr_we(clr_we), .mask_we(mask_we), .txctl_we(txctl_we)
  );

  // Graceful stop completes immediately on request.
  assign grace_req = txctl_we && bus_wdata[0];
  assign set_lines = src_pulse | (LINE_CNT'(grace_req) << GRACE_IDX);
  assign set_vec   = spread(set_lines);

  evt_store u_store (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(clr_we), .clr_val(bus_wdata),
    .mask_we(mask_we), .mask_val(bus_wdata),
    .evt_q(evt_q), .mask_q(mask_q)
  );

  assign active_word = evt_q & mask_q;

  evt_line_out u_out (
    .clk(clk), .rst_n(rst_n), .active_word(active_word), .irq_q(irq_o)
  );

  always_comb begin
    if (hit_evt)       bus_rdata = evt_q;
    else if (hit_mask) bus_rdata = mask_q;
    else               bus_rdata = '0;
  end

  a_r6_grace_sets: assert property (@(posedge clk) disable iff (!rst_n)
    grace_req |=> evt_q[line_bit(GRACE_IDX)]);
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [12:0] src_pulse = '0;
  logic [12:0] irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam int POS [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bit_of(int i);
    return 32'h1 << POS[i];
  endfunction

  function automatic logic [12:0] lines_of(logic [31:0] ev, logic [31:0] mk);
    logic [12:0] l;
    for (int i = 0; i < 13; i++) l[i] = ev[POS[i]] & mk[POS[i]];
    return l;
  endfunction

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(logic [12:0] p);
    @(negedge clk);
    src_pulse = p;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h004, d); chk("R1 event", d, 0);
    rd(10'h008, d); chk("R1 mask", d, 0);
    chk("R1 lines", 32'(irq_o), 0);
  endtask

  task automatic t_each_line();
    logic [31:0] d;
    wr(10'h008, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      pulse(13'h1 << i);
      rd(10'h004, d); chk($sformatf("R2 line %0d bit", i), d, bit_of(i));
      chk($sformatf("R5 line %0d", i), 32'(irq_o), 32'h1 << i);
      wr(10'h004, bit_of(i));
      rd(10'h004, d); chk($sformatf("R3 clear line %0d", i), d, 0);
    end
  endtask

  task automatic t_partial_clear();
    logic [31:0] d;
    pulse(13'b111);
    wr(10'h004, bit_of(1));
    rd(10'h004, d); chk("R3 partial", d, bit_of(0) | bit_of(2));
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_mask_pattern();
    logic [31:0] d;
    logic [31:0] mk = 32'hA5A5_5A5A;
    logic [31:0] all = '0;
    for (int i = 0; i < 13; i++) all |= bit_of(i);
    wr(10'h008, mk);
    rd(10'h008, d); chk("R4 mask readback", d, mk);
    pulse(13'h1FFF);
    rd(10'h004, d); chk("R2 all set", d, all);
    chk("R5 patterned", 32'(irq_o), 32'(lines_of(all, mk)));
    wr(10'h008, 32'h0);
    chk("R8 old state held", 32'(irq_o), 32'(lines_of(all, mk)));
    @(negedge clk);
    chk("R8 mask off next", 32'(irq_o), 0);
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, d); chk("R9 upper bits zero", d, 0);
    rd(10'h00C, d); chk("R9 other offset", d, 0);
  endtask

  task automatic t_grace();
    logic [31:0] d;
    wr(10'h008, 32'hFFFF_FFFF);
    wr(10'h0C4, 32'h2);
    rd(10'h004, d); chk("R6 bit0 clear", d, 0);
    wr(10'h0C4, 32'h1);
    rd(10'h004, d); chk("R6 grace set", d, 32'h1000_0000);
    chk("R5 grace line", 32'(irq_o), 32'h1 << 9);
    wr(10'h004, 32'h1000_0000);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(13'b10);
    @(negedge clk);
    bus_addr = 10'h004; bus_wr = 1; bus_wdata = bit_of(0) | bit_of(1);
    src_pulse = 13'b1;
    @(negedge clk);
    bus_wr = 0; src_pulse = '0;
    rd(10'h004, d); chk("R7 set wins", d, bit_of(0));
    wr(10'h004, bit_of(0));
  endtask

  task automatic t_timing();
    @(negedge clk);
    src_pulse = 13'h1 << 4;
    @(negedge clk);
    src_pulse = '0;
    chk("R8 not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R8 one clock later", 32'(irq_o), 32'h1 << 4);
    wr(10'h004, bit_of(4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_each_line();
    t_partial_clear();
    t_mask_pattern();
    t_grace();
    t_collide();
    t_timing();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule